// File: doc/BRIEF.md
# Inter-Peer Doorbell Interrupt Controller

This block is the register front end of a shared-memory device that several peers attach to. Each peer owns a 256-byte register window with four 32-bit registers: an interrupt enable mask, an interrupt cause register, a read-only position holding the peer's own ID, and a write-only doorbell. A peer raises an event on another peer by writing the doorbell with a destination ID and a vector number. The event sets one pending flag at the destination. Each peer has a level interrupt line that reflects both its masked cause bits and its pending vector flags.

Each peer has its own access port. A request is one cycle long and is marked by a valid strobe. A read returns its data one cycle later with a response strobe. There is no back-pressure: every request is accepted in the cycle it is presented, and doorbells from several peers in the same cycle are all delivered. Pending flags are consumed through a per-vector acknowledge pulse, which takes the place of the interrupt delivery logic that sits outside this block.

Top module: `dbl_doorbell_ctrl`

## Requirements
- R1: After reset, every peer's mask and cause registers read zero, its position reads its own index (so peer 0 reads zero), all pending flags are clear and every interrupt line is low.
- R2: Within a window the byte offset selects the register: 0 is the mask, 4 is the cause, 8 is the position and 12 is the doorbell. Every other offset of the 8-bit window, misaligned ones included, reads as zero, and writes to it change nothing.
- R3: The mask is a full 32-bit read/write register, so a value written is read back unchanged, all ones included.
- R4: A write to the cause register ORs the written bits into it. A read returns the current value and clears the register in the same cycle, so a read that follows at once returns zero.
- R5: The position register is read-only. It reads the peer's index, which is distinct for every peer, and writes to it are ignored.
- R6: The doorbell is write-only. A read of it returns zero and changes no register and no pending flag.
- R7: A doorbell write carries the destination peer ID in bits 31:16 and the vector number in bits 15:0. It sets that vector's pending flag at the destination on the clock edge that accepts the write.
- R8: A doorbell whose destination ID is not below the number of peers, or whose vector is not below the vector count, is dropped and sets nothing.
- R9: An acknowledge pulse on a vector clears that pending flag on the next edge. If a doorbell sets the same flag in that same cycle, the flag stays set.
- R10: A peer's interrupt line is high exactly while the AND of its cause and mask is non-zero or any of its pending flags is set.
- R11: A read request yields a response strobe for exactly one cycle, one cycle later, and the response carries the register value from before the access. A write yields no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PEERS | Per-peer request strobe |
| req_write | input | NUM_PEERS | Per-peer direction, 1 = write |
| req_addr | input | NUM_PEERS*8 | Per-peer byte offset within the window |
| req_wdata | input | NUM_PEERS*32 | Per-peer write data |
| rsp_valid | output | NUM_PEERS | Per-peer read response strobe |
| rsp_data | output | NUM_PEERS*32 | Per-peer read data |
| vec_ack | input | NUM_PEERS*NUM_VEC | Acknowledge pulse, one bit per vector per peer |
| vec_pend | output | NUM_PEERS*NUM_VEC | Pending vector flags, one bit per vector per peer |
| irq | output | NUM_PEERS | Per-peer level interrupt |

## Verification
The bench builds the block with four peers, two vectors per peer and a 16-bit ID field. With these values the random doorbells can name destinations 4 and 5, which do not exist, and vector 2, which is out of range, so dropping is exercised next to valid routing to every peer. Two vectors per peer is enough to show that an acknowledge clears only its own flag and that a doorbell and an acknowledge landing on the same flag in the same cycle leave it set. Four peers also give each position read a distinct expected value.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

  localparam int ADDR_W   = 8;
  localparam int OFS_MASK = 0;
  localparam int OFS_CAUS = 4;
  localparam int OFS_POS  = 8;
  localparam int OFS_BELL = 12;

  typedef enum logic [2:0] {
    SEL_MASK,
    SEL_CAUS,
    SEL_POS,
    SEL_BELL,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] ofs);
    reg_sel_e sel;
    case (ofs)
      ADDR_W'(OFS_MASK): sel = SEL_MASK;
      ADDR_W'(OFS_CAUS): sel = SEL_CAUS;
      ADDR_W'(OFS_POS):  sel = SEL_POS;
      ADDR_W'(OFS_BELL): sel = SEL_BELL;
      default:           sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/dbl_peer_regs.sv
module dbl_peer_regs
  import dbl_pkg::*;
#(
  parameter int PEER_IDX = 0,
  parameter int DATA_W   = 32,
  parameter int ID_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_data,
  output logic                   cause_hit,
  output logic                   bell_valid,
  output logic [ID_W-1:0]        bell_dest,
  output logic [DATA_W-ID_W-1:0] bell_vec
);
  localparam int VF_W = DATA_W - ID_W;

  reg_sel_e          sel;
  logic              rd_en;
  logic              wr_en;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] cause_q;
  logic [DATA_W-1:0] rd_val;

  assign sel   = decode_offset(req_addr);
  assign rd_en = req_valid && !req_write;
  assign wr_en = req_valid && req_write;

  always_comb begin
    case (sel)
      SEL_MASK: rd_val = mask_q;
      SEL_CAUS: rd_val = cause_q;
      SEL_POS:  rd_val = DATA_W'(PEER_IDX);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      cause_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) begin
        rsp_data <= rd_val;
      end
      if (wr_en && sel == SEL_MASK) begin
        mask_q <= req_wdata;
      end
      if (wr_en && sel == SEL_CAUS) begin
        cause_q <= cause_q | req_wdata;
      end else if (rd_en && sel == SEL_CAUS) begin
        cause_q <= '0;
      end
    end
  end

  assign cause_hit  = |(cause_q & mask_q);
  assign bell_valid = wr_en && (sel == SEL_BELL);
  assign bell_dest  = req_wdata[DATA_W-1 -: ID_W];
  assign bell_vec   = req_wdata[VF_W-1:0];

endmodule

// File: rtl/dbl_router.sv
module dbl_router #(
  parameter int NUM_PEERS = 4,
  parameter int NUM_VEC   = 2,
  parameter int ID_W      = 16,
  parameter int VF_W      = 16
) (
  input  logic [NUM_PEERS-1:0]         bell_valid,
  input  logic [NUM_PEERS*ID_W-1:0]    bell_dest,
  input  logic [NUM_PEERS*VF_W-1:0]    bell_vec,
  output logic [NUM_PEERS*NUM_VEC-1:0] vec_set
);

  for (genvar d = 0; d < NUM_PEERS; d++) begin : g_dest
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int s = 0; s < NUM_PEERS; s++) begin
          if (bell_valid[s]
              && bell_dest[s*ID_W +: ID_W] == ID_W'(d)
              && bell_vec[s*VF_W +: VF_W] == VF_W'(v)) begin
            hit = 1'b1;
          end
        end
      end
      assign vec_set[d*NUM_VEC + v] = hit;
    end
  end

endmodule

// File: rtl/dbl_pending.sv
module dbl_pending #(
  parameter int NUM_VEC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] set_i,
  input  logic [NUM_VEC-1:0] ack_i,
  output logic [NUM_VEC-1:0] pend_o
);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_o[v] <= 1'b0;
      end else if (set_i[v]) begin
        pend_o[v] <= 1'b1;
      end else if (ack_i[v]) begin
        pend_o[v] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dbl_doorbell_ctrl.sv
module dbl_doorbell_ctrl
  import dbl_pkg::*;
#(
  parameter int NUM_PEERS = 4,
  parameter int NUM_VEC   = 2,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PEERS-1:0]         req_valid,
  input  logic [NUM_PEERS-1:0]         req_write,
  input  logic [NUM_PEERS*ADDR_W-1:0]  req_addr,
  input  logic [NUM_PEERS*DATA_W-1:0]  req_wdata,
  output logic [NUM_PEERS-1:0]         rsp_valid,
  output logic [NUM_PEERS*DATA_W-1:0]  rsp_data,
  input  logic [NUM_PEERS*NUM_VEC-1:0] vec_ack,
  output logic [NUM_PEERS*NUM_VEC-1:0] vec_pend,
  output logic [NUM_PEERS-1:0]         irq
);
  localparam int VF_W = DATA_W - ID_W;

  logic [NUM_PEERS-1:0]         bell_valid;
  logic [NUM_PEERS*ID_W-1:0]    bell_dest;
  logic [NUM_PEERS*VF_W-1:0]    bell_vec;
  logic [NUM_PEERS*NUM_VEC-1:0] vec_set;
  logic [NUM_PEERS-1:0]         cause_hit;

  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_peer
    dbl_peer_regs #(
      .PEER_IDX (p),
      .DATA_W   (DATA_W),
      .ID_W     (ID_W)
    ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid[p]),
      .req_write  (req_write[p]),
      .req_addr   (req_addr[p*ADDR_W +: ADDR_W]),
      .req_wdata  (req_wdata[p*DATA_W +: DATA_W]),
      .rsp_valid  (rsp_valid[p]),
      .rsp_data   (rsp_data[p*DATA_W +: DATA_W]),
      .cause_hit  (cause_hit[p]),
      .bell_valid (bell_valid[p]),
      .bell_dest  (bell_dest[p*ID_W +: ID_W]),
      .bell_vec   (bell_vec[p*VF_W +: VF_W])
    );

    dbl_pending #(
      .NUM_VEC (NUM_VEC)
    ) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (vec_set[p*NUM_VEC +: NUM_VEC]),
      .ack_i  (vec_ack[p*NUM_VEC +: NUM_VEC]),
      .pend_o (vec_pend[p*NUM_VEC +: NUM_VEC])
    );

    assign irq[p] = cause_hit[p] || (|vec_pend[p*NUM_VEC +: NUM_VEC]);
  end

  dbl_router #(
    .NUM_PEERS (NUM_PEERS),
    .NUM_VEC   (NUM_VEC),
    .ID_W      (ID_W),
    .VF_W      (VF_W)
  ) u_router (
    .bell_valid (bell_valid),
    .bell_dest  (bell_dest),
    .bell_vec   (bell_vec),
    .vec_set    (vec_set)
  );

endmodule

// File: rtl/dbl_doorbell_ctrl_chk.sv
module dbl_doorbell_ctrl_chk
  import dbl_pkg::*;
#(
  parameter int NUM_PEERS = 4,
  parameter int NUM_VEC   = 2,
  parameter int DATA_W    = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_PEERS-1:0]         req_valid,
  input logic [NUM_PEERS-1:0]         req_write,
  input logic [NUM_PEERS*ADDR_W-1:0]  req_addr,
  input logic [NUM_PEERS-1:0]         rsp_valid,
  input logic [NUM_PEERS*DATA_W-1:0]  rsp_data,
  input logic [NUM_PEERS*NUM_VEC-1:0] vec_ack,
  input logic [NUM_PEERS*NUM_VEC-1:0] vec_pend,
  input logic [NUM_PEERS-1:0]         irq
);
  logic any_write;
  assign any_write = |(req_valid & req_write);

  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_peer
    logic rd_caus;
    logic rd_pos;
    logic rd_bell;
    assign rd_caus = req_valid[p] && !req_write[p]
                     && req_addr[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_CAUS);
    assign rd_pos  = req_valid[p] && !req_write[p]
                     && req_addr[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_POS);
    assign rd_bell = req_valid[p] && !req_write[p]
                     && req_addr[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_BELL);

    AST_RSP_TRACKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[p] == $past(req_valid[p] && !req_write[p])); // R11

    AST_CAUSE_SECOND_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[p] && $past(rd_caus, 1) && $past(rd_caus, 2)
      |-> rsp_data[p*DATA_W +: DATA_W] == '0); // R4

    AST_POS_IS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[p] && $past(rd_pos)
      |-> rsp_data[p*DATA_W +: DATA_W] == DATA_W'(p)); // R5

    AST_BELL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[p] && $past(rd_bell)
      |-> rsp_data[p*DATA_W +: DATA_W] == '0); // R6

    AST_PEND_LIFTS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (|vec_pend[p*NUM_VEC +: NUM_VEC]) |-> irq[p]); // R10

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      AST_PEND_NEEDS_BELL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_pend[p*NUM_VEC + v]) |-> $past(any_write)); // R7

      AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vec_ack[p*NUM_VEC + v] && !any_write)
        |-> !vec_pend[p*NUM_VEC + v]); // R9
    end
  end

endmodule

bind dbl_doorbell_ctrl dbl_doorbell_ctrl_chk #(
  .NUM_PEERS (NUM_PEERS),
  .NUM_VEC   (NUM_VEC),
  .DATA_W    (DATA_W)
) u_chk (.*);

// File: tb/dbl_doorbell_ctrl_tb.sv
module dbl_doorbell_ctrl_tb;
  import dbl_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int P  = 4;
  localparam int V  = 2;
  localparam int DW = 32;
  localparam int AW = ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [P-1:0]      req_valid = '0;
  logic [P-1:0]      req_write = '0;
  logic [P*AW-1:0]   req_addr = '0;
  logic [P*DW-1:0]   req_wdata = '0;
  logic [P-1:0]      rsp_valid;
  logic [P*DW-1:0]   rsp_data;
  logic [P*V-1:0]    vec_ack = '0;
  logic [P*V-1:0]    vec_pend;
  logic [P-1:0]      irq;

  int n_checks = 0;
  int n_fail   = 0;

  logic [DW-1:0] m_mask  [P];
  logic [DW-1:0] m_cause [P];
  logic [V-1:0]  m_pend  [P];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbl_doorbell_ctrl #(.NUM_PEERS(P), .NUM_VEC(V), .DATA_W(DW), .ID_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .vec_ack(vec_ack), .vec_pend(vec_pend), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int p, logic [7:0] a);
    case (a)
      8'd0:    return m_mask[p];
      8'd4:    return m_cause[p];
      8'd8:    return 32'(p);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [P*V-1:0] exp_pend();
    logic [P*V-1:0] f;
    for (int q = 0; q < P; q++) f[q*V +: V] = m_pend[q];
    return f;
  endfunction

  function automatic logic [P-1:0] exp_irq();
    logic [P-1:0] r;
    for (int q = 0; q < P; q++) r[q] = (|(m_cause[q] & m_mask[q])) || (|m_pend[q]);
    return r;
  endfunction

  // One access on peer p, entered and left at a falling edge.
  task automatic access(string tag, int p, bit wr, logic [7:0] a,
                        logic [31:0] d, logic [P*V-1:0] ack);
    logic [31:0] exp_rd;
    int dest;
    int vec;
    exp_rd = exp_read(p, a);
    req_valid = '0;
    req_valid[p] = 1'b1;
    req_write[p] = wr;
    req_addr[p*AW +: AW] = a;
    req_wdata[p*DW +: DW] = d;
    vec_ack = ack;
    @(posedge clk);
    @(negedge clk);
    req_valid = '0;
    vec_ack = '0;
    check({tag, " R11 rsp_valid"}, 32'(rsp_valid[p]), 32'(!wr));
    if (!wr) check({tag, " read data"}, rsp_data[p*DW +: DW], exp_rd);
    // model update
    dest = int'(d[31:16]);
    vec  = int'(d[15:0]);
    for (int q = 0; q < P; q++) begin
      for (int v = 0; v < V; v++) begin
        if (wr && a == 8'd12 && dest == q && vec == v) m_pend[q][v] = 1'b1;
        else if (ack[q*V + v]) m_pend[q][v] = 1'b0;
      end
    end
    if (wr && a == 8'd0) m_mask[p] = d;
    if (wr && a == 8'd4) m_cause[p] = m_cause[p] | d;
    if (!wr && a == 8'd4) m_cause[p] = '0;
    check({tag, " pending flags"}, 32'(vec_pend), 32'(exp_pend()));
    check({tag, " R10 irq"}, 32'(irq), 32'(exp_irq()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] addrs [5];
    addrs[0] = 8'd0; addrs[1] = 8'd4; addrs[2] = 8'd8; addrs[3] = 8'd12; addrs[4] = 8'd24;
    void'($urandom(32'd20240611));
    for (int q = 0; q < P; q++) begin
      m_mask[q] = '0; m_cause[q] = '0; m_pend[q] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pend after reset", 32'(vec_pend), 32'd0);
    check("R1 irq after reset", 32'(irq), 32'd0);
    for (int q = 0; q < P; q++) begin
      access("R1 mask", q, 1'b0, 8'd0, 32'd0, '0);
      access("R1 cause", q, 1'b0, 8'd4, 32'd0, '0);
      access("R1 R5 position", q, 1'b0, 8'd8, 32'd0, '0);
    end

    // R3 mask round trip
    access("R3 mask write", 0, 1'b1, 8'd0, 32'hFFFF_FFFF, '0);
    access("R3 mask read", 0, 1'b0, 8'd0, 32'd0, '0);
    access("R3 mask pattern", 1, 1'b1, 8'd0, 32'hA5C3_0F10, '0);
    access("R3 mask pattern read", 1, 1'b0, 8'd0, 32'd0, '0);

    // R4 cause set, read, clear
    access("R4 cause set", 0, 1'b1, 8'd4, 32'd1, '0);
    access("R4 cause or", 0, 1'b1, 8'd4, 32'h8000_0000, '0);
    access("R4 cause first read", 0, 1'b0, 8'd4, 32'd0, '0);
    access("R4 cause second read", 0, 1'b0, 8'd4, 32'd0, '0);

    // R5 position is read-only
    access("R5 position write", 2, 1'b1, 8'd8, 32'd7, '0);
    access("R5 position read", 2, 1'b0, 8'd8, 32'd0, '0);

    // R2 unmapped offsets
    access("R2 unmapped write", 0, 1'b1, 8'd16, 32'h1234_5678, '0);
    access("R2 unmapped read", 0, 1'b0, 8'd16, 32'd0, '0);
    access("R2 misaligned read", 0, 1'b0, 8'd3, 32'd0, '0);
    access("R2 misaligned write", 1, 1'b1, 8'd1, 32'hFFFF_FFFF, '0);
    access("R2 mask kept", 1, 1'b0, 8'd0, 32'd0, '0);
    access("R2 top offset read", 3, 1'b0, 8'd255, 32'd0, '0);

    // R6 doorbell read
    access("R6 doorbell read", 3, 1'b0, 8'd12, 32'd0, '0);

    // R7 routing
    access("R7 bell 2->0 v0", 2, 1'b1, 8'd12, {16'd0, 16'd0}, '0);
    access("R7 bell 0->2 v1", 0, 1'b1, 8'd12, {16'd2, 16'd1}, '0);
    access("R7 bell 3->3 v1", 3, 1'b1, 8'd12, {16'd3, 16'd1}, '0);

    // R8 dropped doorbells
    access("R8 dest too large", 1, 1'b1, 8'd12, {16'd4, 16'd0}, '0);
    access("R8 dest far", 1, 1'b1, 8'd12, {16'h8001, 16'd1}, '0);
    access("R8 vec too large", 1, 1'b1, 8'd12, {16'd1, 16'd2}, '0);
    access("R8 vec high bits", 1, 1'b1, 8'd12, {16'd1, 16'h0100}, '0);

    // R9 acknowledge and set-wins
    access("R9 ack peer0 v0", 1, 1'b0, 8'd0, 32'd0, (P*V)'(1) << (0*V + 0));
    access("R9 set peer1 v0", 0, 1'b1, 8'd12, {16'd1, 16'd0}, '0);
    access("R9 set and ack same", 2, 1'b1, 8'd12, {16'd1, 16'd0}, (P*V)'(1) << (1*V + 0));
    access("R9 ack alone", 2, 1'b0, 8'd8, 32'd0, (P*V)'(1) << (1*V + 0));
    access("R9 ack two peers", 0, 1'b0, 8'd0, 32'd0,
           ((P*V)'(1) << (2*V + 1)) | ((P*V)'(1) << (3*V + 1)));

    // R10 masked cause drives irq
    access("R10 cause unmasked", 2, 1'b1, 8'd4, 32'h10, '0);
    access("R10 mask on", 2, 1'b1, 8'd0, 32'h10, '0);
    access("R10 mask off", 2, 1'b1, 8'd0, 32'h01, '0);
    access("R10 mask on again", 2, 1'b1, 8'd0, 32'h30, '0);
    access("R10 cause drained", 2, 1'b0, 8'd4, 32'd0, '0);

    // random mix
    for (int i = 0; i < 500; i++) begin
      int p;
      int op;
      logic [P*V-1:0] ack;
      p  = int'($urandom % P);
      op = int'($urandom % 5);
      ack = ($urandom % 4 == 0) ? (P*V)'($urandom) : '0;
      case (op)
        0: access("R2 random read", p, 1'b0, addrs[$urandom % 5], 32'd0, ack);
        1: access("R3 random mask", p, 1'b1, 8'd0, $urandom & $urandom, ack);
        2: access("R4 random cause", p, 1'b1, 8'd4, 32'(1) << ($urandom % 32), ack);
        3: access("R7 R8 random bell", p, 1'b1, 8'd12,
                  {16'($urandom % 6), 16'($urandom % 3)}, ack);
        default: access("R9 random ack", p, 1'b0, 8'd4, 32'd0, (P*V)'($urandom));
      endcase
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule